// File: doc/BRIEF.md
# Scalar Accumulator ALU Execute Stage

This block is the execute step of a 32-bit scalar unit that has three general registers (A, X, Y) and two condition flags (carry and zero). It takes one ALU-class instruction word per cycle and splits it into an operation code, a destination selector and two source selectors. It picks the operands and computes the result together with the new flags. The write-back is a single clock edge into a small register bank held in the same wrapper. Operand selector codes also stand for constants: the first source can be a literal zero and the second source can be a 16-bit immediate taken from the instruction's low bits.

Instruction fetch, memory access and jumps belong elsewhere. The registered wrapper holds only what is needed to see the effect of each instruction on the registers and the flags.

Top module: `scalar_alu_stage`

## Requirements
- R1: An instruction takes effect on the rising clock edge only when `instr_valid` is high and `instr[31:30]` equals `2'b01`. Otherwise registers and flags keep their values.
- R2: The operation code is `instr[29:26]` and the destination selector is `instr[25:24]`, with 00 meaning no register, 01 A, 10 X and 11 Y. At most one register is written per instruction.
- R3: The first source selector is `instr[23:22]`, with 00 meaning the constant zero, 01 A, 10 X and 11 Y.
- R4: The second source selector is `instr[21:20]`, with 00 meaning `instr[15:0]` zero-extended to 32 bits, 01 A, 10 X and 11 Y.
- R5: Code 0000 adds. Code 0001 adds plus the incoming carry. Carry becomes the unsigned carry out of bit 31.
- R6: Code 0010 subtracts the second source from the first. Code 0011 also subtracts the incoming carry. Carry becomes 1 exactly when a borrow occurs.
- R7: Code 0100 increments the first source and code 0110 decrements it. The second source has no effect. Carry is the carry out for the increment and the borrow for the decrement.
- R8: Codes 1000, 1001 and 1010 give bitwise AND, OR and XOR, and leave carry unchanged.
- R9: Code 1011 gives the low 32 bits of the unsigned product and clears carry.
- R10: Codes 1100 to 1111 move the first source by one bit. 1100 shifts left inserting 0, 1101 rotates left inserting the carry, 1110 shifts right inserting 0, and 1111 rotates right inserting the carry. In each case the bit moved out becomes the new carry.
- R11: After every defined operation, zero is 1 exactly when the result is zero. Both flags update even when the destination selector is 00.
- R12: Codes 0101 and 0111 write no register and change no flag.
- R13: While `rst_n` is low, all registers and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| reg_a | output | 32 | Register A |
| reg_x | output | 32 | Register X |
| reg_y | output | 32 | Register Y |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
Directed sequences first build known register contents through zero-extended immediates, then reach the edges. These cover all-ones wrapping to zero on increment, a decrement from the constant zero, a compare with no destination, a product that overflows, and rotates that pull the carry in. Each of these separates carry-out, borrow, flag-only and operand-selection behaviour. Seeded random instruction streams then mix every operation code and selector combination, including the unused codes, words outside the ALU class and cycles with valid low. A bench reference model catches swapped selector codes, wrong carry polarity or carry leaking into the logic operations.

// File: rtl/scalar_alu_pkg.sv
package scalar_alu_pkg;

    localparam int INSTR_W   = 32;
    localparam int CLASS_MSB = 31;
    localparam int OP_LSB    = 26;
    localparam int DST_LSB   = 24;
    localparam int SRC1_LSB  = 22;
    localparam int SRC2_LSB  = 20;
    localparam int NUM_REGS  = 3;

    localparam logic [1:0] CLASS_ALU = 2'b01;
    localparam logic [1:0] SEL_NONE  = 2'b00;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_ADC  = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SBC  = 4'b0011,
        OP_INC  = 4'b0100,
        OP_RSV5 = 4'b0101,
        OP_DEC  = 4'b0110,
        OP_RSV7 = 4'b0111,
        OP_AND  = 4'b1000,
        OP_OR   = 4'b1001,
        OP_XOR  = 4'b1010,
        OP_MUL  = 4'b1011,
        OP_SHL  = 4'b1100,
        OP_RCL  = 4'b1101,
        OP_SHR  = 4'b1110,
        OP_RCR  = 4'b1111
    } alu_op_e;

    function automatic logic op_is_defined(alu_op_e op);
        return (op != OP_RSV5) && (op != OP_RSV7);
    endfunction

    function automatic logic op_keeps_carry(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/salu_decode.sv
module salu_decode
    import scalar_alu_pkg::*;
#(
    parameter int IMM_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_alu,
    output alu_op_e            op,
    output logic [1:0]         dst_sel,
    output logic [1:0]         src1_sel,
    output logic [1:0]         src2_sel,
    output logic [IMM_W-1:0]   imm
);

    localparam int GAP_W = SRC2_LSB - IMM_W;

    logic [GAP_W-1:0] unused_gap;

    always_comb begin
        is_alu     = (instr[CLASS_MSB -: 2] == CLASS_ALU);
        op         = alu_op_e'(instr[OP_LSB +: 4]);
        dst_sel    = instr[DST_LSB +: 2];
        src1_sel   = instr[SRC1_LSB +: 2];
        src2_sel   = instr[SRC2_LSB +: 2];
        imm        = instr[IMM_W-1:0];
        unused_gap = instr[SRC2_LSB-1:IMM_W];
    end

endmodule

// File: rtl/salu_operand_sel.sv
module salu_operand_sel
    import scalar_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [1:0]                      src1_sel,
    input  logic [1:0]                      src2_sel,
    input  logic [IMM_W-1:0]                imm,
    output logic [DATA_W-1:0]               opnd_s,
    output logic [DATA_W-1:0]               opnd_t
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{1'b0}}, imm};

        if (src1_sel == SEL_NONE) begin
            opnd_s = '0;
        end else begin
            opnd_s = regs[src1_sel - 2'd1];
        end

        if (src2_sel == SEL_NONE) begin
            opnd_t = imm_ext;
        end else begin
            opnd_t = regs[src2_sel - 2'd1];
        end
    end

endmodule

// File: rtl/salu_compute.sv
module salu_compute
    import scalar_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opnd_s,
    input  logic [DATA_W-1:0] opnd_t,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              zero_out
);

    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]  s_ext;
    logic [EXT_W-1:0]  t_ext;
    logic [EXT_W-1:0]  add_ext;
    logic [EXT_W-1:0]  sub_ext;
    logic [EXT_W-1:0]  inc_ext;
    logic [EXT_W-1:0]  dec_ext;
    logic [DATA_W-1:0] prod_lo;
    logic              add_cin;
    logic              sub_bin;

    always_comb begin
        s_ext   = {1'b0, opnd_s};
        t_ext   = {1'b0, opnd_t};
        add_cin = (op == OP_ADC) ? carry_in : 1'b0;
        sub_bin = (op == OP_SBC) ? carry_in : 1'b0;
        add_ext = s_ext + t_ext + {{DATA_W{1'b0}}, add_cin};
        sub_ext = s_ext - t_ext - {{DATA_W{1'b0}}, sub_bin};
        inc_ext = s_ext + {{DATA_W{1'b0}}, 1'b1};
        dec_ext = s_ext - {{DATA_W{1'b0}}, 1'b1};
        prod_lo = opnd_s * opnd_t;
    end

    always_comb begin
        result    = '0;
        carry_out = carry_in;
        unique case (op)
            OP_ADD, OP_ADC: begin
                result    = add_ext[DATA_W-1:0];
                carry_out = add_ext[DATA_W];
            end
            OP_SUB, OP_SBC: begin
                result    = sub_ext[DATA_W-1:0];
                carry_out = sub_ext[DATA_W];
            end
            OP_INC: begin
                result    = inc_ext[DATA_W-1:0];
                carry_out = inc_ext[DATA_W];
            end
            OP_DEC: begin
                result    = dec_ext[DATA_W-1:0];
                carry_out = dec_ext[DATA_W];
            end
            OP_AND: result = opnd_s & opnd_t;
            OP_OR:  result = opnd_s | opnd_t;
            OP_XOR: result = opnd_s ^ opnd_t;
            OP_MUL: begin
                result    = prod_lo;
                carry_out = 1'b0;
            end
            OP_SHL: begin
                result    = {opnd_s[DATA_W-2:0], 1'b0};
                carry_out = opnd_s[DATA_W-1];
            end
            OP_RCL: begin
                result    = {opnd_s[DATA_W-2:0], carry_in};
                carry_out = opnd_s[DATA_W-1];
            end
            OP_SHR: begin
                result    = {1'b0, opnd_s[DATA_W-1:1]};
                carry_out = opnd_s[0];
            end
            OP_RCR: begin
                result    = {carry_in, opnd_s[DATA_W-1:1]};
                carry_out = opnd_s[0];
            end
            default: begin
                result    = '0;
                carry_out = carry_in;
            end
        endcase
        zero_out = (result == '0);
    end

endmodule

// File: rtl/scalar_alu_stage.sv
module scalar_alu_stage
    import scalar_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [DATA_W-1:0]  reg_a,
    output logic [DATA_W-1:0]  reg_x,
    output logic [DATA_W-1:0]  reg_y,
    output logic               flag_c,
    output logic               flag_z
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            carry;
        logic                            zero;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic              is_alu;
    alu_op_e           op;
    logic [1:0]        dst_sel;
    logic [1:0]        src1_sel;
    logic [1:0]        src2_sel;
    logic [IMM_W-1:0]  imm;
    logic [DATA_W-1:0] opnd_s;
    logic [DATA_W-1:0] opnd_t;
    logic [DATA_W-1:0] alu_res;
    logic              alu_carry;
    logic              alu_zero;
    logic              fire;
    logic              commit;
    logic [NUM_REGS-1:0] wr_en;

    salu_decode #(
        .IMM_W (IMM_W)
    ) u_decode (
        .instr    (instr),
        .is_alu   (is_alu),
        .op       (op),
        .dst_sel  (dst_sel),
        .src1_sel (src1_sel),
        .src2_sel (src2_sel),
        .imm      (imm)
    );

    salu_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_operands (
        .regs     (state_q.regs),
        .src1_sel (src1_sel),
        .src2_sel (src2_sel),
        .imm      (imm),
        .opnd_s   (opnd_s),
        .opnd_t   (opnd_t)
    );

    salu_compute #(
        .DATA_W (DATA_W)
    ) u_compute (
        .op        (op),
        .opnd_s    (opnd_s),
        .opnd_t    (opnd_t),
        .carry_in  (state_q.carry),
        .result    (alu_res),
        .carry_out (alu_carry),
        .zero_out  (alu_zero)
    );

    assign fire   = instr_valid && is_alu;
    assign commit = fire && op_is_defined(op);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_wr_en
        assign wr_en[gi] = commit && (dst_sel == 2'(gi + 1));
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en[i]) begin
                state_d.regs[i] = alu_res;
            end
        end
        if (commit) begin
            if (!op_keeps_carry(op)) begin
                state_d.carry = alu_carry;
            end
            state_d.zero = alu_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_a  = state_q.regs[0];
    assign reg_x  = state_q.regs[1];
    assign reg_y  = state_q.regs[2];
    assign flag_c = state_q.carry;
    assign flag_z = state_q.zero;

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(state_q));

    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_no_dest_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (dst_sel == SEL_NONE) |=> $stable(state_q.regs));

    p_logic_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op_keeps_carry(op) |=> $stable(flag_c));

    p_mul_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (op == OP_MUL) |=> !flag_c);

    p_zero_tracks_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (dst_sel == 2'b01) |=> (flag_z == (reg_a == '0)));

    p_unused_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !op_is_defined(op) |=> $stable(state_q));

endmodule

// File: tb/tb_scalar_alu_stage.sv
module tb_scalar_alu_stage;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] x;
        logic [31:0] y;
        logic        c;
        logic        z;
    } mstate_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] reg_a, reg_x, reg_y;
    logic        flag_c, flag_z;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    mstate_t model_q;

    always #5 clk = ~clk;

    scalar_alu_stage dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .reg_a       (reg_a),
        .reg_x       (reg_x),
        .reg_y       (reg_y),
        .flag_c      (flag_c),
        .flag_z      (flag_z)
    );

    function automatic logic [31:0] enc(logic [3:0] op, logic [1:0] d,
                                        logic [1:0] s, logic [1:0] t,
                                        logic [15:0] im);
        return {2'b01, op, d, s, t, 4'b0000, im};
    endfunction

    function automatic logic [31:0] rd(mstate_t m, logic [1:0] sel, logic [31:0] k);
        case (sel)
            2'b01:   return m.a;
            2'b10:   return m.x;
            2'b11:   return m.y;
            default: return k;
        endcase
    endfunction

    function automatic mstate_t model(mstate_t m, logic v, logic [31:0] w);
        mstate_t     n = m;
        logic [3:0]  op = w[29:26];
        logic [1:0]  d  = w[25:24];
        logic [31:0] s  = rd(m, w[23:22], 32'd0);
        logic [31:0] t  = rd(m, w[21:20], {16'd0, w[15:0]});
        logic [32:0] wide;
        logic [63:0] prod;
        logic [31:0] r;
        logic        c = m.c;
        if (!v || w[31:30] != 2'b01 || op == 4'd5 || op == 4'd7) return m;
        case (op)
            4'h0: begin wide = {1'b0, s} + {1'b0, t}; r = wide[31:0]; c = wide[32]; end
            4'h1: begin wide = {1'b0, s} + {1'b0, t} + {32'd0, m.c}; r = wide[31:0]; c = wide[32]; end
            4'h2: begin r = s - t; c = (s < t); end
            4'h3: begin r = s - t - {31'd0, m.c}; c = ({1'b0, s} < ({1'b0, t} + {32'd0, m.c})); end
            4'h4: begin r = s + 1; c = (s == 32'hFFFF_FFFF); end
            4'h6: begin r = s - 1; c = (s == 32'd0); end
            4'h8: r = s & t;
            4'h9: r = s | t;
            4'hA: r = s ^ t;
            4'hB: begin prod = {32'd0, s} * {32'd0, t}; r = prod[31:0]; c = 1'b0; end
            4'hC: begin r = s << 1; c = s[31]; end
            4'hD: begin r = (s << 1) | {31'd0, m.c}; c = s[31]; end
            4'hE: begin r = s >> 1; c = s[0]; end
            default: begin r = (s >> 1) | {m.c, 31'd0}; c = s[0]; end
        endcase
        n.c = c;
        n.z = (r == 32'd0);
        case (d)
            2'b01: n.a = r;
            2'b10: n.x = r;
            2'b11: n.y = r;
            default: ;
        endcase
        return n;
    endfunction

    function automatic string tag_of(logic v, logic [31:0] w);
        if (!v || w[31:30] != 2'b01) return "R1";
        case (w[29:26])
            4'h0, 4'h1: return "R5";
            4'h2, 4'h3: return "R6";
            4'h4, 4'h6: return "R7";
            4'h8, 4'h9, 4'hA: return "R8";
            4'hB: return "R9";
            4'h5, 4'h7: return "R12";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, mstate_t exp);
        mstate_t got = {reg_a, reg_x, reg_y, flag_c, flag_z};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got a=%h x=%h y=%h c=%b z=%b exp a=%h x=%h y=%h c=%b z=%b",
                     tag, got.a, got.x, got.y, got.c, got.z,
                     exp.a, exp.x, exp.y, exp.c, exp.z);
        end
    endtask

    // Called at a falling edge; checks after the next rising edge, at the falling edge.
    task automatic step(string tag, logic v, logic [31:0] w);
        model_q     = model(model_q, v, w);
        instr_valid = v;
        instr       = w;
        @(negedge clk);
        check(tag, model_q);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_q = '0;
        // R13: reset clears the state while reset is held, even with a valid instruction.
        instr_valid = 1'b1;
        instr       = enc(4'h9, 2'b01, 2'b00, 2'b00, 16'h1234);
        repeat (3) @(negedge clk);
        check("R13", '0);
        instr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R13", '0);

        step("R4", 1'b1, enc(4'h9, 2'b01, 2'b00, 2'b00, 16'hFFFF)); // A = zero-extended imm
        step("R4", 1'b1, enc(4'h0, 2'b10, 2'b01, 2'b01, 16'h0000)); // X = A + A
        step("R3", 1'b1, enc(4'h0, 2'b11, 2'b10, 2'b00, 16'h0002)); // Y = X + 2
        step("R3", 1'b1, enc(4'h6, 2'b01, 2'b00, 2'b10, 16'h0000)); // A = 0 - 1, borrow
        step("R7", 1'b1, enc(4'h4, 2'b11, 2'b01, 2'b10, 16'h0000)); // Y = A + 1 wraps
        step("R11", 1'b1, enc(4'h2, 2'b00, 2'b10, 2'b10, 16'h0000)); // compare X,X
        step("R2", 1'b1, enc(4'h0, 2'b00, 2'b01, 2'b00, 16'h0001)); // flags only
        step("R9", 1'b1, enc(4'hB, 2'b10, 2'b01, 2'b01, 16'h0000)); // all ones squared
        step("R10", 1'b1, enc(4'hD, 2'b01, 2'b10, 2'b00, 16'h0000));
        step("R10", 1'b1, enc(4'hF, 2'b10, 2'b10, 2'b00, 16'h0000));
        step("R8", 1'b1, enc(4'hA, 2'b11, 2'b11, 2'b01, 16'h0000));
        step("R12", 1'b1, enc(4'h5, 2'b01, 2'b01, 2'b01, 16'h0000));
        step("R12", 1'b1, enc(4'h7, 2'b10, 2'b01, 2'b01, 16'h0000));
        step("R1", 1'b0, enc(4'h9, 2'b01, 2'b00, 2'b00, 16'h00AA));
        step("R1", 1'b1, {2'b10, enc(4'h9, 2'b01, 2'b00, 2'b00, 16'h00AA)});
        step("R6", 1'b1, enc(4'h3, 2'b01, 2'b00, 2'b00, 16'h0001));

        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            logic        v  = ($urandom % 10) != 0;
            logic [31:0] w  = $urandom;
            if (($urandom % 8) != 0) w[31:30] = 2'b01;
            if (($urandom % 3) == 0) w[15:0] = ($urandom % 2) ? 16'hFFFF : 16'h0000;
            step(tag_of(v, w), v, w);
        end

        instr_valid = 1'b0;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule